// File: doc/BRIEF.md
# Destructive-Read DRAM Bank Sequencer

This block schedules requests to a single embedded-DRAM cache bank whose cells are emptied by every read. Callers present read and write requests with a valid/ready handshake. Accepted requests enter a four-entry queue. A phase machine takes them out one at a time and drives the bank through an access phase. A read adds a restore phase after the access phase, which writes the sensed value back into the row.

Read data is returned with a one-cycle `rd_valid` pulse as soon as the access phase ends. The bank stays occupied until the restore has finished, and no queued request can start before that. Because of this, a run of reads to the bank is spaced by the access time plus the restore time. A write skips the restore and frees the bank once its access phase ends. The `busy` output is high while any request is queued or in flight. Integrators use it to detect when the bank has gone quiet.

The bank storage is modelled inside the block with a row array. Sensing a row clears it, and the restore writes the sensed value back. A missing or misdirected restore therefore appears as wrong data on a later read.

Top module: `drbank_seq`

## Requirements
- R1: After reset `req_ready` is 1, `busy` is 0 and `rd_valid` is 0.
- R2: The queue holds 4 requests. `req_ready` is 0 while 4 requests are waiting. A request offered while `req_ready` is 0 is not taken, and it is accepted once space opens, with none lost.
- R3: Requests are served strictly in the order they were accepted, and read data returns in that order.
- R4: For a read accepted while the bank is idle, `rd_valid` is high for exactly one cycle, in the cycle after the (ACC_CYC+1)-th rising edge that follows the accepting edge. `rd_data` is valid in that cycle.
- R5: Every read is followed by a restore phase of RST_CYC cycles. For a lone read, `busy` first reads 0 in the cycle after the (ACC_CYC+RST_CYC+1)-th edge that follows acceptance.
- R6: A write has no restore phase. For a lone write, `busy` first reads 0 in the cycle after the (ACC_CYC+1)-th edge that follows acceptance.
- R7: The restore preserves the data. Repeated reads of a row return the value last written to it, and a row never written returns 0.
- R8: No access starts during a restore. Two queued reads produce `rd_valid` pulses exactly ACC_CYC+RST_CYC cycles apart.
- R9: A read queued behind a write to the same address returns the newly written data, ACC_CYC cycles after the write's access phase ends.
- R10: `busy` is 1 from the cycle after a request is accepted until its access phase (writes) or restore phase (reads) is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has space; request taken on a rising edge when valid and ready are both 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Row address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle pulse carrying read data |
| rd_data | output | DATA_W | Sensed read data |
| busy | output | 1 | A request is queued or the bank is in an access or restore phase |

## Verification
The hardest state to reach from the ports is a full queue that sits behind a read that is still restoring. Reaching it requires requests to arrive faster than the bank drains them, while the head request is in its blocking restore. The bench gets there by issuing six reads on consecutive cycles and holding each request until `req_ready` returns. It records the cycle and value of every `rd_valid` pulse, which checks order, spacing and the loss-free stall together. A separate write-then-read pair, queued back to back, covers the forwarding of new data through the array.

// File: rtl/drbank_pkg.sv
package drbank_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ACCESS  = 2'd1,
    PH_RESTORE = 2'd2
  } phase_e;

endpackage

// File: rtl/drbank_fifo.sv
module drbank_fifo #(
  parameter int W     = 13,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     ent_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d;
  logic [PTR_W-1:0] rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q,  cnt_d;

  // entry storage: one enabled register per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = push && (wptr_q == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[i] <= '0;
      end else if (slot_en) begin
        ent_q[i] <= din;
      end
    end
  end

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push) begin
      wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    end
    if (pop) begin
      rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    end
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign dout  = ent_q[rptr_q];
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);  // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);  // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (cnt_q == $past(cnt_q) + 1'b1));  // R2

endmodule

// File: rtl/drbank_array.sv
module drbank_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              sense_en,
  input  logic              restore_en,
  output logic [DATA_W-1:0] sense_data
);

  localparam int ROWS = 1 << ADDR_W;

  logic [DATA_W-1:0] row_q [ROWS];
  logic [DATA_W-1:0] sense_q;

  // each row: write, destructive sense (clears), or restore of the sensed value
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic hit;
    assign hit = (addr == ADDR_W'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q[r] <= '0;
      end else if (hit && wr_en) begin
        row_q[r] <= wdata;
      end else if (hit && sense_en) begin
        row_q[r] <= '0;
      end else if (hit && restore_en) begin
        row_q[r] <= sense_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
    end else if (sense_en) begin
      sense_q <= row_q[addr];
    end
  end

  assign sense_data = sense_q;

  AST_ONE_BANK_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, sense_en, restore_en}));  // R8
  AST_SENSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sense_en |=> (row_q[$past(addr)] == '0));  // R7

endmodule

// File: rtl/drbank_phase.sv
module drbank_phase
  import drbank_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int ACC_CYC = 3,
  parameter int RST_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty,
  input  logic              head_wr,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [DATA_W-1:0] head_data,
  output logic              pop,
  output logic              arr_wr_en,
  output logic              arr_sense_en,
  output logic              arr_restore_en,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_data,
  output logic              rd_valid,
  output logic              active
);

  localparam int MAX_CYC = (ACC_CYC > RST_CYC) ? ACC_CYC : RST_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ACC_LOAD = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'(RST_CYC - 1);

  phase_e            state_q, state_d;
  logic [CNT_W-1:0]  cnt_q,   cnt_d;
  logic              op_wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              rdv_q,   rdv_d;
  logic              phase_end;

  assign phase_end = (cnt_q == '0);

  always_comb begin
    state_d        = state_q;
    cnt_d          = cnt_q;
    rdv_d          = 1'b0;
    pop            = 1'b0;
    arr_wr_en      = 1'b0;
    arr_sense_en   = 1'b0;
    arr_restore_en = 1'b0;
    case (state_q)
      PH_IDLE: begin
        if (!q_empty) begin
          pop     = 1'b1;
          state_d = PH_ACCESS;
          cnt_d   = ACC_LOAD;
        end
      end
      PH_ACCESS: begin
        if (!phase_end) begin
          cnt_d = cnt_q - 1'b1;
        end else if (op_wr_q) begin
          arr_wr_en = 1'b1;
          if (!q_empty) begin
            pop     = 1'b1;
            state_d = PH_ACCESS;
            cnt_d   = ACC_LOAD;
          end else begin
            state_d = PH_IDLE;
          end
        end else begin
          arr_sense_en = 1'b1;
          rdv_d        = 1'b1;
          state_d      = PH_RESTORE;
          cnt_d        = RST_LOAD;
        end
      end
      PH_RESTORE: begin
        if (!phase_end) begin
          cnt_d = cnt_q - 1'b1;
        end else begin
          arr_restore_en = 1'b1;
          if (!q_empty) begin
            pop     = 1'b1;
            state_d = PH_ACCESS;
            cnt_d   = ACC_LOAD;
          end else begin
            state_d = PH_IDLE;
          end
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      rdv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rdv_q   <= rdv_d;
    end
  end

  // request capture, enabled by the pop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_wr_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (pop) begin
      op_wr_q <= head_wr;
      addr_q  <= head_addr;
      data_q  <= head_data;
    end
  end

  assign cur_addr = addr_q;
  assign cur_data = data_q;
  assign rd_valid = rdv_q;
  assign active   = (state_q != PH_IDLE);

  AST_READ_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_ACCESS && phase_end && !op_wr_q) |=> (state_q == PH_RESTORE));  // R5
  AST_WRITE_NO_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_ACCESS && phase_end && op_wr_q) |=> (state_q != PH_RESTORE));  // R6
  AST_NO_POP_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_RESTORE && !phase_end) |-> !pop);  // R8
  AST_RDV_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (state_q == PH_RESTORE));  // R4

endmodule

// File: rtl/drbank_seq.sv
module drbank_seq #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int ACC_CYC    = 3,
  parameter int RST_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);

  localparam int REQ_W = 1 + ADDR_W + DATA_W;

  logic              push, pop, q_full, q_empty;
  logic [REQ_W-1:0]  q_din, q_dout;
  logic              head_wr;
  logic [ADDR_W-1:0] head_addr, cur_addr;
  logic [DATA_W-1:0] head_data, cur_data;
  logic              arr_wr_en, arr_sense_en, arr_restore_en;
  logic              active;

  assign req_ready = !q_full;
  assign push      = req_valid && req_ready;
  assign q_din     = {req_write, req_addr, req_wdata};
  assign {head_wr, head_addr, head_data} = q_dout;

  drbank_fifo #(
    .W     (REQ_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (q_din),
    .pop   (pop),
    .dout  (q_dout),
    .full  (q_full),
    .empty (q_empty)
  );

  drbank_phase #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ACC_CYC (ACC_CYC),
    .RST_CYC (RST_CYC)
  ) u_phase (
    .clk            (clk),
    .rst_n          (rst_n),
    .q_empty        (q_empty),
    .head_wr        (head_wr),
    .head_addr      (head_addr),
    .head_data      (head_data),
    .pop            (pop),
    .arr_wr_en      (arr_wr_en),
    .arr_sense_en   (arr_sense_en),
    .arr_restore_en (arr_restore_en),
    .cur_addr       (cur_addr),
    .cur_data       (cur_data),
    .rd_valid       (rd_valid),
    .active         (active)
  );

  drbank_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (cur_addr),
    .wdata      (cur_data),
    .wr_en      (arr_wr_en),
    .sense_en   (arr_sense_en),
    .restore_en (arr_restore_en),
    .sense_data (rd_data)
  );

  assign busy = active || !q_empty;

  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> busy);  // R10
  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);  // R4
  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> req_ready);  // R2

endmodule

// File: tb/drbank_seq_tb.sv
module drbank_seq_tb;

  localparam int ACC = 3;
  localparam int RST = 2;
  localparam int NV  = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_write, req_ready, rd_valid, busy;
  logic [3:0] req_addr;
  logic [7:0] req_wdata, rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  drbank_seq #(
    .ADDR_W(4), .DATA_W(8), .FIFO_DEPTH(4), .ACC_CYC(ACC), .RST_CYC(RST)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy)
  );

  // {write, addr, wdata, expected read data}
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 4'h3, 8'hA5, 8'h00},
    {1'b1, 4'h7, 8'h3C, 8'h00},
    {1'b0, 4'h3, 8'h00, 8'hA5},
    {1'b0, 4'h3, 8'h00, 8'hA5},
    {1'b0, 4'h7, 8'h00, 8'h3C},
    {1'b1, 4'h3, 8'h5A, 8'h00},
    {1'b0, 4'h3, 8'h00, 8'h5A},
    {1'b0, 4'h0, 8'h00, 8'h00},
    {1'b1, 4'hF, 8'hFF, 8'h00},
    {1'b0, 4'hF, 8'h00, 8'hFF}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
    end
  end

  // collector for queued bursts
  int   col_n;
  int   col_t [8];
  logic [7:0] col_d [8];

  initial begin : main
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    rst_n = 1;
    @(negedge clk);

    // table walk: each request alone on an idle bank
    for (int v = 0; v < NV; v++) begin
      logic       w;
      logic [7:0] exp_d;
      int rd_k, idle_k, npulse, k;
      logic [7:0] got;
      w = VEC[v][20];
      exp_d = VEC[v][7:0];
      req_valid = 1; req_write = w; req_addr = VEC[v][19:16]; req_wdata = VEC[v][15:8];
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
      rd_k = -1; idle_k = -1; npulse = 0; got = 0; k = 0;
      while (idle_k < 0 && k < 40) begin
        if (rd_valid) begin npulse++; if (rd_k < 0) begin rd_k = k; got = rd_data; end end
        if (!busy) idle_k = k;
        else begin @(negedge clk); k++; end
      end
      if (w) begin
        chk(idle_k == ACC + 1, "R6 write busy length", idle_k, ACC + 1);
        chk(npulse == 0, "R6 write no rd_valid", npulse, 0);
      end else begin
        chk(rd_k == ACC + 1, "R4 read latency", rd_k, ACC + 1);
        chk(npulse == 1, "R4 single pulse", npulse, 1);
        chk(got == exp_d, "R7 read data", int'(got), int'(exp_d));
        chk(idle_k == ACC + RST + 1, "R5 restore holds busy", idle_k, ACC + RST + 1);
      end
    end

    // burst of six queued reads: fills the queue behind a restoring read
    begin
      logic [3:0] ba [6] = '{4'h3, 4'h7, 4'hF, 4'h3, 4'h7, 4'hF};
      logic [7:0] bd [6] = '{8'h5A, 8'h3C, 8'hFF, 8'h5A, 8'h3C, 8'hFF};
      bit saw_full;
      saw_full = 0;
      col_n = 0;
      fork
        begin : issuer
          for (int i = 0; i < 6; i++) begin
            req_valid = 1; req_write = 0; req_addr = ba[i]; req_wdata = 0;
            while (!req_ready) begin saw_full = 1; @(negedge clk); end
            @(posedge clk);
            @(negedge clk);
          end
          req_valid = 0;
        end
        begin : collector
          for (int t = 0; t < 60; t++) begin
            if (rd_valid && col_n < 8) begin
              col_t[col_n] = t; col_d[col_n] = rd_data; col_n++;
            end
            @(negedge clk);
          end
        end
      join
      chk(saw_full == 1'b1, "R2 ready low when full", int'(saw_full), 1);
      chk(col_n == 6, "R2 no request lost", col_n, 6);
      for (int i = 0; i < 6; i++)
        chk(col_d[i] == bd[i], "R3 order of read data", int'(col_d[i]), int'(bd[i]));
      for (int i = 1; i < 6; i++)
        chk(col_t[i] - col_t[i-1] == ACC + RST, "R8 read spacing",
            col_t[i] - col_t[i-1], ACC + RST);
      chk(busy == 1'b0, "R10 busy clears after burst", int'(busy), 0);
    end

    // write then read to the same row, queued back to back
    begin
      int k, rk;
      logic [7:0] got;
      req_valid = 1; req_write = 1; req_addr = 4'h5; req_wdata = 8'h77;
      @(posedge clk);
      @(negedge clk);
      req_write = 0; req_wdata = 0;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      // k counts negedges after the write's accepting edge; now at k = 1
      k = 1; rk = -1; got = 0;
      while (k < 30) begin
        if (rd_valid && rk < 0) begin rk = k; got = rd_data; end
        @(negedge clk); k++;
      end
      chk(got == 8'h77, "R9 read sees new write", int'(got), 8'h77);
      chk(rk == ACC + 1 + ACC, "R9 read timing after write", rk, 2 * ACC + 1);
    end

    // unwritten row reads 0 (R7)
    begin
      int k;
      logic [7:0] got;
      bit seen;
      req_valid = 1; req_write = 0; req_addr = 4'hC;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      seen = 0; got = 8'hEE;
      for (k = 0; k < 10; k++) begin
        if (rd_valid) begin seen = 1; got = rd_data; end
        @(negedge clk);
      end
      chk(seen && got == 8'h00, "R7 unwritten row", int'(got), 0);
    end

    done = 1;
    finish_run();
  end

endmodule